// File: doc/BRIEF.md
# Reprogrammable Twiddle Bank Controller

This block supplies the twiddle factors for a streaming radix-2 number-theoretic-transform datapath that handles `X` words per cycle over `log2(N)` stages, with `X/2` butterfly ways per stage. Each (stage, way) pair owns a small memory of `N/X` entries per bank. During a transform, every stage reads its memories with one shared address that steps through the entries once per cycle and wraps, so a new transform can start every `N/X` cycles. Each cycle the block presents one twiddle per (stage, way).

Several banks are kept and used in rotation. A bank holds the twiddles for one residue channel. While one bank serves the datapath, the next bank in the rotation is refilled from a twiddle stream that delivers `X/2` words per beat. Each memory has its own programming counter, built from an offset, a step and a lane. The counter picks its words out of the shared stream and produces that memory's write enable and write address. A refilled bank goes live only on the next transform-start strobe.

The programming sequencer is a three-state machine. `PS_IDLE` waits for a start. `PS_FILL` counts stream beats while the counters write. `PS_HOLD` holds a fully written bank until it is switched in. The transitions are: start (`PS_IDLE` to `PS_FILL`), all counters finished (`PS_FILL` to `PS_HOLD`), and transform-start strobe (`PS_HOLD` to `PS_IDLE`, with a bank swap).

Top module: `twiddle_bank_ctrl`

## Requirements
- R1: After reset, `act_bank` is 0, every twiddle word on `tw_out` is 0, and `prg_busy` and `bank_ready` are both low.
- R2: When `next_in` is sampled high at a clock edge, `tw_out` shows entry 0 of the active bank after that edge. It then moves forward one entry per cycle and returns to entry 0 after entry `N/X-1`.
- R3: The memory of stage s and way u takes lane u of stream beat number `s + k*log2(N)` as its entry k (offset s, step log2(N), lane u). Beats are numbered from 0, and only cycles in `PS_FILL` with `prg_valid` high count as beats.
- R4: The memory ignores stream words whose beat number or lane does not match its counter. It also ignores words sent while `prg_valid` is low, and beats that arrive after its final entry has been written.
- R5: Programming writes only the bank that follows the active bank in cyclic order, `(act_bank+1) mod NBANK`. The active bank's output stays unchanged while filling is in progress.
- R6: `prg_busy` is high exactly in `PS_FILL`. `bank_ready` is high exactly in `PS_HOLD`, which is entered in the cycle after every counter has written its final entry.
- R7: `act_bank` changes only on a `next_in` strobe while `bank_ready` is high. A strobe at any other time only restarts the read address.
- R8: `prg_start` is ignored unless the sequencer is in `PS_IDLE`. In particular, a start sent during filling does not restart the beat numbering.
- R9: The twiddle for stage s and way u sits at bits `[(s*X/2+u)*W +: W]` of `tw_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prg_start | input | 1 | Begin refilling the next bank |
| prg_valid | input | 1 | Stream beat present on `prg_data` |
| prg_data | input | X/2*W | Stream beat, lane j at bits `[j*W +: W]` |
| next_in | input | 1 | Transform-start strobe |
| tw_out | output | log2(N)*X/2*W | One twiddle per (stage, way) |
| act_bank | output | clog2(NBANK) | Bank currently read |
| prg_busy | output | 1 | Filling in progress |
| bank_ready | output | 1 | Refilled bank waiting to be switched in |

## Verification
The bench builds the block with N=16, X=4, W=16 and NBANK=3. This gives four stages, two ways and four-entry memories, so one refill takes sixteen beats. Three banks let three successive refills walk the whole rotation and wrap back to bank 0, which a two-bank build would never show. The short period lets every read window be checked through a full wrap. The mid-fill strobe, the stray start, the gapped stream and the surplus beats then each fit inside a single refill.

// File: rtl/tw_pkg.sv
package tw_pkg;
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_FILL = 2'd1,
        PS_HOLD = 2'd2
    } prg_state_t;
endpackage

// File: rtl/tw_prg_counter.sv
// Selects one memory's entries out of the shared twiddle stream.
module tw_prg_counter #(
    parameter int P      = 4,
    parameter int BW     = 6,
    parameter int AW     = 2,
    parameter int OFFSET = 0,
    parameter int STEP   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          beat_valid,
    input  logic [BW-1:0] beat_idx,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          done
);
    logic [BW-1:0] nxt_beat;
    logic [AW-1:0] entry;

    assign we    = beat_valid && !done && (beat_idx == nxt_beat);
    assign waddr = entry;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            nxt_beat <= BW'(OFFSET);
            entry    <= '0;
            done     <= 1'b0;
        end else if (we) begin
            nxt_beat <= nxt_beat + BW'(STEP);
            if (entry == AW'(P - 1)) begin
                done  <= 1'b1;
                entry <= '0;
            end else begin
                entry <= entry + AW'(1);
            end
        end
    end
endmodule

// File: rtl/tw_mem.sv
// Storage for one (stage, way): NB banks of P words.
module tw_mem #(
    parameter int NB  = 2,
    parameter int P   = 4,
    parameter int W   = 16,
    parameter int AW  = 2,
    parameter int BKW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [BKW-1:0] wbank,
    input  logic [AW-1:0]  waddr,
    input  logic [W-1:0]   wdata,
    input  logic [BKW-1:0] rbank,
    input  logic [AW-1:0]  raddr,
    output logic [W-1:0]   rdata
);
    localparam int DEPTH = NB * P;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (we) begin
            store[int'(wbank) * P + int'(waddr)] <= wdata;
        end
    end

    assign rdata = store[int'(rbank) * P + int'(raddr)];
endmodule

// File: rtl/tw_bank_seq.sv
// Programming state machine, bank rotation and cyclic read address.
module tw_bank_seq
    import tw_pkg::*;
#(
    parameter int NB  = 2,
    parameter int P   = 4,
    parameter int BW  = 6,
    parameter int AW  = 2,
    parameter int BKW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           prg_start,
    input  logic           prg_valid,
    input  logic           next_in,
    input  logic           all_done,
    output logic           clear_cnt,
    output logic           beat_valid,
    output logic [BW-1:0]  beat_idx,
    output logic [AW-1:0]  rd_addr,
    output logic [BKW-1:0] act_bank,
    output logic [BKW-1:0] fill_bank,
    output logic           prg_busy,
    output logic           bank_ready
);
    prg_state_t state, state_nx;
    logic [BKW-1:0] succ_bank;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE: if (prg_start) state_nx = PS_FILL;
            PS_FILL: if (all_done)  state_nx = PS_HOLD;
            PS_HOLD: if (next_in)   state_nx = PS_IDLE;
            default: state_nx = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        clear_cnt  = 1'b0;
        beat_valid = 1'b0;
        prg_busy   = 1'b0;
        bank_ready = 1'b0;
        unique case (state)
            PS_IDLE: clear_cnt = prg_start;
            PS_FILL: begin
                prg_busy   = 1'b1;
                beat_valid = prg_valid;
            end
            PS_HOLD: bank_ready = 1'b1;
            default: ;
        endcase
    end

    assign succ_bank = (act_bank == BKW'(NB - 1)) ? '0 : act_bank + BKW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_idx  <= '0;
            rd_addr   <= '0;
            act_bank  <= '0;
            fill_bank <= '0;
        end else begin
            if (clear_cnt) begin
                beat_idx  <= '0;
                fill_bank <= succ_bank;
            end else if (beat_valid) begin
                beat_idx <= beat_idx + BW'(1);
            end
            if (bank_ready && next_in) act_bank <= fill_bank;
            if (next_in || rd_addr == AW'(P - 1)) rd_addr <= '0;
            else                                   rd_addr <= rd_addr + AW'(1);
        end
    end
endmodule

// File: rtl/twiddle_bank_ctrl.sv
module twiddle_bank_ctrl #(
    parameter int N     = 16,
    parameter int X     = 4,
    parameter int W     = 16,
    parameter int NBANK = 2,
    localparam int S    = $clog2(N),
    localparam int U    = X / 2,
    localparam int P    = N / X,
    localparam int AW   = (P > 1) ? $clog2(P) : 1,
    localparam int BKW  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int BW   = $clog2(S * P + S + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prg_start,
    input  logic             prg_valid,
    input  logic [U*W-1:0]   prg_data,
    input  logic             next_in,
    output logic [S*U*W-1:0] tw_out,
    output logic [BKW-1:0]   act_bank,
    output logic             prg_busy,
    output logic             bank_ready
);
    logic           clear_cnt;
    logic           beat_valid;
    logic [BW-1:0]  beat_idx;
    logic [AW-1:0]  rd_addr;
    logic [BKW-1:0] fill_bank;
    logic [S*U-1:0] done_vec;
    logic           all_done;

    assign all_done = &done_vec;

    tw_bank_seq #(.NB(NBANK), .P(P), .BW(BW), .AW(AW), .BKW(BKW)) u_seq (
        .clk(clk), .rst_n(rst_n), .prg_start(prg_start), .prg_valid(prg_valid),
        .next_in(next_in), .all_done(all_done), .clear_cnt(clear_cnt),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .rd_addr(rd_addr),
        .act_bank(act_bank), .fill_bank(fill_bank), .prg_busy(prg_busy),
        .bank_ready(bank_ready)
    );

    for (genvar gs = 0; gs < S; gs++) begin : g_stage
        for (genvar gu = 0; gu < U; gu++) begin : g_way
            localparam int SLOT = gs * U + gu;
            logic          we;
            logic [AW-1:0] waddr;

            tw_prg_counter #(.P(P), .BW(BW), .AW(AW), .OFFSET(gs), .STEP(S)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clear(clear_cnt), .beat_valid(beat_valid),
                .beat_idx(beat_idx), .we(we), .waddr(waddr), .done(done_vec[SLOT])
            );

            tw_mem #(.NB(NBANK), .P(P), .W(W), .AW(AW), .BKW(BKW)) u_mem (
                .clk(clk), .rst_n(rst_n), .we(we), .wbank(fill_bank), .waddr(waddr),
                .wdata(prg_data[gu*W +: W]), .rbank(act_bank), .raddr(rd_addr),
                .rdata(tw_out[SLOT*W +: W])
            );
        end
    end
endmodule

// File: rtl/tw_bank_checker.sv
module tw_bank_checker #(
    parameter int P   = 4,
    parameter int AW  = 2,
    parameter int BKW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           next_in,
    input logic [BKW-1:0] act_bank,
    input logic [BKW-1:0] fill_bank,
    input logic           prg_busy,
    input logic           bank_ready,
    input logic [AW-1:0]  rd_addr,
    input logic           all_done
);
    a_r7_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !next_in |=> $stable(act_bank));

    a_r7_swap_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (next_in && !bank_ready) |=> $stable(act_bank));

    a_r6_busy_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prg_busy && bank_ready));

    a_r6_ready_all_written: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ready |-> all_done);

    a_r5_fill_not_active: assert property (@(posedge clk) disable iff (!rst_n)
        prg_busy |-> (fill_bank != act_bank));

    a_r2_restart_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        next_in |=> (rd_addr == '0));

    a_r2_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (!next_in && rd_addr == AW'(P - 1)) |=> (rd_addr == '0));
endmodule

bind twiddle_bank_ctrl tw_bank_checker #(.P(P), .AW(AW), .BKW(BKW)) u_chk (
    .clk(clk), .rst_n(rst_n), .next_in(next_in), .act_bank(act_bank),
    .fill_bank(fill_bank), .prg_busy(prg_busy), .bank_ready(bank_ready),
    .rd_addr(rd_addr), .all_done(all_done)
);

// File: tb/sim_twiddle_bank_ctrl.sv
module sim_twiddle_bank_ctrl;
    localparam int N = 16, X = 4, W = 16, NB = 3;
    localparam int S = 4, U = 2, P = 4, BEATS = S * P;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prg_start = 1'b0, prg_valid = 1'b0, next_in = 1'b0;
    logic [U*W-1:0] prg_data = '0;
    logic [S*U*W-1:0] tw_out;
    logic [1:0] act_bank;
    logic prg_busy, bank_ready;

    int n_chk = 0, n_bad = 0;
    int exp_tw [NB][S][U][P];
    int act_m = 0;

    always #10 clk = ~clk;

    twiddle_bank_ctrl #(.N(N), .X(X), .W(W), .NBANK(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .prg_start(prg_start), .prg_valid(prg_valid),
        .prg_data(prg_data), .next_in(next_in), .tw_out(tw_out),
        .act_bank(act_bank), .prg_busy(prg_busy), .bank_ready(bank_ready)
    );

    function automatic int word_of(int rnd, int beat, int lane);
        return rnd * 4096 + beat * 16 + lane;
    endfunction

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // R2/R9/R7: called with next_in already driven high at a negedge
    task automatic t_window(string req);
        @(negedge clk);
        next_in = 1'b0;
        for (int c = 0; c <= P; c++) begin
            chk({req, " act_bank"}, int'(act_bank), act_m);
            for (int s = 0; s < S; s++)
                for (int u = 0; u < U; u++)
                    chk({req, " R2 R9 word"}, int'(tw_out[(s*U+u)*W +: W]),
                        exp_tw[act_m][s][u][c % P]);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 act_bank", int'(act_bank), 0);
        chk("R1 tw_out zero", int'(tw_out == '0), 1);
        chk("R1 prg_busy", int'(prg_busy), 0);
        chk("R1 bank_ready", int'(bank_ready), 0);
    endtask

    task automatic t_program(int rnd, bit gaps, bit extra, bit stray, bit mid_strobe);
        int tgt = (act_m + 1) % NB;
        prg_start = 1'b1;
        @(negedge clk);
        prg_start = 1'b0;
        chk("R6 busy in fill", int'(prg_busy), 1);
        for (int b = 0; b < BEATS; b++) begin
            if (gaps && (b % 3 == 1)) begin
                prg_valid = 1'b0;
                prg_data  = {16'hDEAD, 16'hBEEF}; // R4 words with valid low
                @(negedge clk);
            end
            if (mid_strobe && b == 8) begin
                prg_valid = 1'b0;
                next_in = 1'b1;                   // R7 strobe while filling
                t_window("R5 R7 mid-fill");
            end
            prg_valid = 1'b1;
            prg_start = stray && (b == 5);        // R8 stray start
            for (int l = 0; l < U; l++) prg_data[l*W +: W] = W'(word_of(rnd, b, l));
            @(negedge clk);
            prg_start = 1'b0;
        end
        if (extra) begin                          // R4 surplus beats
            for (int e = 0; e < 3; e++) begin
                prg_data = {16'hFFFF, 16'h7777};
                @(negedge clk);
            end
        end
        prg_valid = 1'b0;
        @(negedge clk);
        chk("R6 ready after fill", int'(bank_ready), 1);
        chk("R6 busy after fill", int'(prg_busy), 0);
        chk("R7 no swap before strobe", int'(act_bank), act_m);
        for (int s = 0; s < S; s++)
            for (int u = 0; u < U; u++)
                for (int k = 0; k < P; k++)
                    exp_tw[tgt][s][u][k] = word_of(rnd, s + k * S, u); // R3
        next_in = 1'b1;
        act_m = tgt;                              // R5 cyclic successor
        t_window("R3 R4 R5 swap");
        chk("R6 ready cleared", int'(bank_ready), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int bk = 0; bk < NB; bk++)
            for (int s = 0; s < S; s++)
                for (int u = 0; u < U; u++)
                    for (int k = 0; k < P; k++) exp_tw[bk][s][u][k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(1, 1'b0, 1'b0, 1'b0, 1'b0);
        next_in = 1'b1;                           // R7 strobe while idle
        t_window("R7 idle strobe");
        t_program(2, 1'b1, 1'b1, 1'b1, 1'b1);
        t_program(3, 1'b0, 1'b0, 1'b0, 1'b0);     // wraps to bank 0
        chk("R5 wrap to bank 0", int'(act_bank), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule